// File: doc/BRIEF.md
# DS3 Transmit Overhead Bit Generator

This block produces the serial bit stream of a DS3 M-frame on the transmit side. A framer calls it once per line bit through a bit-clock enable. For each bit slot it either passes a payload bit from the serial source, passes a bit from the C-bit input, or creates the overhead bit itself. Two combinational strobes tell the sources which input the next enabled edge will consume.

An M-frame holds 4760 bits: 7 subframes of 680 bits, each made of 8 blocks of one overhead bit followed by 84 payload bits. Within a subframe the overhead slots run X/P/M, F1, C1, F2, C2, F3, C3, F4. The block computes the parity of each frame's payload and places it in the P slots of the next frame. Control inputs select the alarm value of the X bits and C-bit parity mode. Two more controls let the C-bits or the whole framing overhead come from outside instead of being generated. The external C-bit path is what lets a repeater pass path parity and far-end error bits through unchanged.

Top module: `ds3_oh_tx`

## Requirements
- R1: A frame is 4760 enabled bits long. Frame bit index i maps to subframe i/680, block (i%680)/85 and slot (i%680)%85, all counted from 0. Slot 0 is the overhead bit and slots 1..84 are payload bits. Payload slots are taken from `pay_in` with `pay_req` high.
- R2: With `ovh_ext` low, the F slots (blocks 1,3,5,7) carry 1,0,0,1 in that order. The M slots (block 0 of subframes 4,5,6) carry 0,1,0.
- R3: With `ovh_ext` low, the X slots (block 0 of subframes 0 and 1) carry 1 when `x_alarm` is low and 0 when it is high.
- R4: With `ovh_ext` low, both P slots (block 0 of subframes 2 and 3) carry the XOR of all payload-slot bits of the previous frame. In the first frame after reset they carry 0.
- R5: With `cpar_mode` high and `cbit_ext` low, every C slot (blocks 2,4,6) is internal: the C slots of subframe 2 carry the current P value and all other C slots carry 1. `cbit_in` is ignored and neither strobe is high in C slots.
- R6: With `cpar_mode` and `cbit_ext` both high, the C slots of subframes 2 and 3 are taken from `cbit_in` with `cbit_req` high. All other C slots stay internal as in R5. `cbit_req` is never high outside those six slots.
- R7: With `cpar_mode` low, every C slot comes from `cbit_in` (with `cbit_req` high) when `cbit_ext` is high, or from `pay_in` (with `pay_req` high) when it is low.
- R8: With `ovh_ext` high, the X, P, M and F slots are taken from `pay_in` with `pay_req` high. The C slots still follow R5 to R7.
- R9: While `bit_en` is low, the frame position, the parity state and `line_out` hold.
- R10: A synchronous reset drives `line_out` to 0, returns the position to frame bit 0 and clears the parity to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable; one line bit per enabled edge |
| pay_in | input | 1 | Serial payload bit, consumed when `pay_req` is high |
| cbit_in | input | 1 | External C-bit, consumed when `cbit_req` is high |
| x_alarm | input | 1 | Drives the X bits to 0 when high |
| cpar_mode | input | 1 | Selects C-bit parity mode |
| cbit_ext | input | 1 | Takes C-bits from `cbit_in` (all of them, or only subframes 2 and 3 in parity mode) |
| ovh_ext | input | 1 | Takes X, P, M and F bits from the payload stream |
| line_out | output | 1 | Framed serial output, registered on each enabled edge |
| pay_req | output | 1 | Current slot takes its bit from `pay_in` |
| cbit_req | output | 1 | Current slot takes its bit from `cbit_in` |

## Verification
The hardest state to reach is a P slot that carries a nonzero parity. This needs one full 4760-bit frame of payload before the bit appears, and it must differ from the zero value that follows reset. Every configuration in the stimulus table therefore runs two complete frames with pseudo-random payload and C-bit streams. A directed test then resets in the middle of the second frame, so that a stale parity would show up in the next frame's P slots. One table row gates the enable every third cycle, so that holding the position and the parity across idle cycles is exercised under the parity pass-through mode.

// File: rtl/ds3_oh_pkg.sv
package ds3_oh_pkg;

    // M-frame layout
    localparam int SUBF_N = 7;
    localparam int BLK_N  = 8;
    localparam int PAY_N  = 84;
    localparam int SLOT_N = PAY_N + 1;
    localparam int FRAME_N = SUBF_N * BLK_N * SLOT_N;

    localparam int SUBF_W = $clog2(SUBF_N);
    localparam int BLK_W  = $clog2(BLK_N);
    localparam int SLOT_W = $clog2(SLOT_N);

    // Subframe ranges for the block-0 overhead slot
    localparam int X_LAST_SUBF = 1;
    localparam int P_LAST_SUBF = 3;
    localparam int M_ONE_SUBF  = 5;
    localparam int PAR_C_SUBF  = 2;
    localparam int PASS_C_SUBF = 3;

    typedef enum logic [2:0] {
        K_PAY = 3'd0,
        K_X   = 3'd1,
        K_P   = 3'd2,
        K_M   = 3'd3,
        K_F   = 3'd4,
        K_C   = 3'd5
    } slot_kind_e;

    typedef struct packed {
        logic [SUBF_W-1:0] subf;
        logic [BLK_W-1:0]  blk;
        logic [SLOT_W-1:0] bitc;
    } frame_pos_t;

    typedef struct packed {
        logic alarm;
        logic cpar;
        logic cext;
        logic oext;
    } tx_cfg_t;

    function automatic slot_kind_e classify(frame_pos_t p);
        if (p.bitc != '0)
            return K_PAY;
        if (p.blk == '0) begin
            if (p.subf <= SUBF_W'(X_LAST_SUBF)) return K_X;
            if (p.subf <= SUBF_W'(P_LAST_SUBF)) return K_P;
            return K_M;
        end
        if (p.blk[0])
            return K_F;
        return K_C;
    endfunction

    // F1..F4 sit in blocks 1,3,5,7 and carry 1,0,0,1
    function automatic logic f_value(logic [BLK_W-1:0] blk);
        return (blk == BLK_W'(1)) || (blk == BLK_W'(BLK_N - 1));
    endfunction

    // M bits in subframes 4,5,6 carry 0,1,0
    function automatic logic m_value(logic [SUBF_W-1:0] subf);
        return subf == SUBF_W'(M_ONE_SUBF);
    endfunction

    function automatic logic pass_c_subf(logic [SUBF_W-1:0] subf);
        return (subf == SUBF_W'(PAR_C_SUBF)) || (subf == SUBF_W'(PASS_C_SUBF));
    endfunction

endpackage

// File: rtl/ds3_oh_position.sv
module ds3_oh_position
    import ds3_oh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    output frame_pos_t pos,
    output logic       frame_last
);

    logic slot_last;
    logic blk_last;
    logic subf_last;

    assign slot_last  = pos.bitc == SLOT_W'(SLOT_N - 1);
    assign blk_last   = pos.blk  == BLK_W'(BLK_N - 1);
    assign subf_last  = pos.subf == SUBF_W'(SUBF_N - 1);
    assign frame_last = slot_last && blk_last && subf_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (adv) begin
            if (!slot_last) begin
                pos.bitc <= pos.bitc + SLOT_W'(1);
            end else begin
                pos.bitc <= '0;
                if (!blk_last) begin
                    pos.blk <= pos.blk + BLK_W'(1);
                end else begin
                    pos.blk <= '0;
                    if (!subf_last)
                        pos.subf <= pos.subf + SUBF_W'(1);
                    else
                        pos.subf <= '0;
                end
            end
        end
    end

    // R1
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        (pos.bitc < SLOT_W'(SLOT_N)) && (pos.subf < SUBF_W'(SUBF_N)));

    // R1
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && frame_last) |=> (pos == '0));

    // R9
    pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(pos));

endmodule

// File: rtl/ds3_oh_parity.sv
module ds3_oh_parity (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic dbit,
    input  logic close,
    output logic par_prev
);

    logic acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= 1'b0;
            par_prev <= 1'b0;
        end else if (close) begin
            par_prev <= acc ^ (take & dbit);
            acc      <= 1'b0;
        end else if (take) begin
            acc <= acc ^ dbit;
        end
    end

    // R4
    par_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !close |=> $stable(par_prev));

endmodule

// File: rtl/ds3_oh_select.sv
module ds3_oh_select
    import ds3_oh_pkg::*;
(
    input  frame_pos_t pos,
    input  tx_cfg_t    cfg,
    input  logic       par_prev,
    input  logic       pay_in,
    input  logic       cbit_in,
    output logic       tx_bit,
    output logic       pay_req,
    output logic       cbit_req,
    output logic       pay_slot
);

    slot_kind_e kind;
    logic       oh_bit;

    always_comb begin
        kind     = classify(pos);
        pay_req  = 1'b0;
        cbit_req = 1'b0;
        oh_bit   = 1'b0;
        unique case (kind)
            K_PAY: pay_req = 1'b1;
            K_X: begin
                oh_bit  = ~cfg.alarm;
                pay_req = cfg.oext;
            end
            K_P: begin
                oh_bit  = par_prev;
                pay_req = cfg.oext;
            end
            K_M: begin
                oh_bit  = m_value(pos.subf);
                pay_req = cfg.oext;
            end
            K_F: begin
                oh_bit  = f_value(pos.blk);
                pay_req = cfg.oext;
            end
            K_C: begin
                if (cfg.cpar) begin
                    if (cfg.cext && pass_c_subf(pos.subf))
                        cbit_req = 1'b1;
                    else if (pos.subf == SUBF_W'(PAR_C_SUBF))
                        oh_bit = par_prev;
                    else
                        oh_bit = 1'b1;
                end else if (cfg.cext) begin
                    cbit_req = 1'b1;
                end else begin
                    pay_req = 1'b1;
                end
            end
            default: oh_bit = 1'b0;
        endcase

        if (pay_req)
            tx_bit = pay_in;
        else if (cbit_req)
            tx_bit = cbit_in;
        else
            tx_bit = oh_bit;
    end

    assign pay_slot = (kind == K_PAY);

endmodule

// File: rtl/ds3_oh_tx.sv
module ds3_oh_tx
    import ds3_oh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic pay_in,
    input  logic cbit_in,
    input  logic x_alarm,
    input  logic cpar_mode,
    input  logic cbit_ext,
    input  logic ovh_ext,
    output logic line_out,
    output logic pay_req,
    output logic cbit_req
);

    tx_cfg_t    cfg;
    frame_pos_t pos;
    logic       frame_last;
    logic       par_prev;
    logic       tx_bit;
    logic       pay_slot;
    slot_kind_e kind_mon;

    always_comb begin
        cfg.alarm = x_alarm;
        cfg.cpar  = cpar_mode;
        cfg.cext  = cbit_ext;
        cfg.oext  = ovh_ext;
    end

    ds3_oh_position u_pos (
        .clk        (clk),
        .rst        (rst),
        .adv        (bit_en),
        .pos        (pos),
        .frame_last (frame_last)
    );

    ds3_oh_parity u_par (
        .clk      (clk),
        .rst      (rst),
        .take     (bit_en && pay_slot),
        .dbit     (pay_in),
        .close    (bit_en && frame_last),
        .par_prev (par_prev)
    );

    ds3_oh_select u_sel (
        .pos      (pos),
        .cfg      (cfg),
        .par_prev (par_prev),
        .pay_in   (pay_in),
        .cbit_in  (cbit_in),
        .tx_bit   (tx_bit),
        .pay_req  (pay_req),
        .cbit_req (cbit_req),
        .pay_slot (pay_slot)
    );

    always_ff @(posedge clk) begin
        if (rst)
            line_out <= 1'b0;
        else if (bit_en)
            line_out <= tx_bit;
    end

    assign kind_mon = classify(pos);

    // R9
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(line_out));

    // R3
    x_alarm_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && kind_mon == K_X && x_alarm && !ovh_ext) |=> !line_out);

    // R4
    p_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && kind_mon == K_P && !ovh_ext) |=> (line_out == $past(par_prev)));

    // R6
    cbit_scope_chk: assert property (@(posedge clk) disable iff (rst)
        (cbit_req && cpar_mode) |-> (kind_mon == K_C && pass_c_subf(pos.subf)));

    // R8
    ovh_req_chk: assert property (@(posedge clk) disable iff (rst)
        (ovh_ext && kind_mon != K_C) |-> (pay_req && !cbit_req));

endmodule

// File: tb/ds3_oh_tx_bench.sv
`timescale 1ns/1ps
module ds3_oh_tx_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic pay_in = 1'b0;
    logic cbit_in = 1'b0;
    logic x_alarm = 1'b0;
    logic cpar_mode = 1'b0;
    logic cbit_ext = 1'b0;
    logic ovh_ext = 1'b0;
    logic line_out, pay_req, cbit_req;

    always #4 clk = ~clk;

    ds3_oh_tx u_ds3_oh_tx (
        .clk(clk), .rst(rst), .bit_en(bit_en), .pay_in(pay_in), .cbit_in(cbit_in),
        .x_alarm(x_alarm), .cpar_mode(cpar_mode), .cbit_ext(cbit_ext), .ovh_ext(ovh_ext),
        .line_out(line_out), .pay_req(pay_req), .cbit_req(cbit_req)
    );

    localparam int FBITS = 4760;
    localparam int NV = 7;
    // {alarm, cpar, cext, oext, gap, pay_req per frame[12:0], cbit_req per frame[4:0]}
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 13'd4704, 5'd0},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 13'd4704, 5'd0},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 13'd4704, 5'd6},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 13'd4725, 5'd0},
        {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 13'd4704, 5'd21},
        {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 13'd4739, 5'd0},
        {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 13'd4739, 5'd21}
    };

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    int   m_idx = 0;
    logic m_acc = 1'b0;
    logic m_par = 1'b0;
    logic prev_line = 1'b0;
    int   cnt_pay = 0;
    int   cnt_cb = 0;
    int   exp_pay = 0;
    int   exp_cb = 0;
    logic [15:0] lp = 16'h1;
    logic [15:0] lc = 16'h1;

    function automatic logic [15:0] lfsr_next(logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at frame bit %0d: actual=%0d expected=%0d",
                     tag, what, m_idx, act, exp);
        end
    endtask

    // Expected slot behaviour from the requirements
    task automatic model(input logic pin, input logic cin,
                         output logic eb, output logic epr, output logic ecr,
                         output logic isp, output string tag);
        int sf, r, bk, b;
        sf = m_idx / 680;
        r  = m_idx % 680;
        bk = r / 85;
        b  = r % 85;
        epr = 1'b0; ecr = 1'b0; isp = 1'b0; eb = 1'b0; tag = "R1";
        if (b != 0) begin
            isp = 1'b1; epr = 1'b1; eb = pin; tag = "R1";
        end else if (bk % 2 == 1 || bk == 0) begin
            if (ovh_ext) begin
                epr = 1'b1; eb = pin; tag = "R8";
            end else if (bk != 0) begin
                eb = (bk == 1 || bk == 7); tag = "R2";
            end else if (sf < 2) begin
                eb = !x_alarm; tag = "R3";
            end else if (sf < 4) begin
                eb = m_par; tag = "R4";
            end else begin
                eb = (sf == 5); tag = "R2";
            end
        end else begin
            if (cpar_mode) begin
                if (cbit_ext && (sf == 2 || sf == 3)) begin
                    ecr = 1'b1; eb = cin; tag = "R6";
                end else begin
                    eb = (sf == 2) ? m_par : 1'b1; tag = "R5";
                end
            end else if (cbit_ext) begin
                ecr = 1'b1; eb = cin; tag = "R7";
            end else begin
                epr = 1'b1; eb = pin; tag = "R7";
            end
        end
    endtask

    task automatic step(input logic en);
        logic eb, epr, ecr, isp;
        string tag;
        @(negedge clk);
        bit_en  = en;
        pay_in  = lp[0];
        cbit_in = lc[0];
        lp = lfsr_next(lp);
        lc = lfsr_next(lc);
        #1;
        if (en) begin
            model(pay_in, cbit_in, eb, epr, ecr, isp, tag);
            check(pay_req === epr, tag, "pay_req", int'(pay_req), int'(epr));
            check(cbit_req === ecr, tag, "cbit_req", int'(cbit_req), int'(ecr));
            @(posedge clk);
            #1;
            check(line_out === eb, tag, "line_out", int'(line_out), int'(eb));
            prev_line = eb;
            if (isp) m_acc = m_acc ^ pay_in;
            if (epr) cnt_pay++;
            if (ecr) cnt_cb++;
            if (m_idx == FBITS - 1) begin
                // R1 frame length and per-frame source counts
                check(cnt_pay == exp_pay, "R1", "pay_req count per frame", cnt_pay, exp_pay);
                check(cnt_cb == exp_cb, "R6", "cbit_req count per frame", cnt_cb, exp_cb);
                m_par = m_acc;
                m_acc = 1'b0;
                cnt_pay = 0;
                cnt_cb = 0;
                m_idx = 0;
            end else begin
                m_idx++;
            end
        end else begin
            @(posedge clk);
            #1;
            check(line_out === prev_line, "R9", "line_out hold while idle",
                  int'(line_out), int'(prev_line));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bit_en = 1'b0;
        repeat (2) @(negedge clk);
        // R10 reset state
        check(line_out === 1'b0, "R10", "line_out in reset", int'(line_out), 0);
        check(cbit_req === 1'b0, "R10", "cbit_req at frame start", int'(cbit_req), 0);
        check(pay_req === ovh_ext, "R10", "pay_req at frame start", int'(pay_req), int'(ovh_ext));
        rst = 1'b0;
        m_idx = 0; m_acc = 1'b0; m_par = 1'b0; prev_line = 1'b0;
        cnt_pay = 0; cnt_cb = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int v = 0; v < NV; v++) begin
            logic gap;
            int bits;
            int gcyc;
            {x_alarm, cpar_mode, cbit_ext, ovh_ext, gap} = VEC[v][22:18];
            exp_pay = int'(VEC[v][17:5]);
            exp_cb  = int'(VEC[v][4:0]);
            lp = 16'hACE1 ^ 16'(v * 16'h1357);
            lc = 16'h5A5A ^ 16'(v * 16'h0F1D);
            do_reset();
            bits = 0;
            gcyc = 0;
            while (bits < 2 * FBITS) begin
                logic en;
                en = !(gap && (gcyc % 3 == 2));
                step(en);
                if (en) bits++;
                gcyc++;
            end
        end

        // Directed: reset in the middle of the second frame clears the parity (R10, R4)
        {x_alarm, cpar_mode, cbit_ext, ovh_ext} = 4'b0100;
        exp_pay = 4704;
        exp_cb  = 0;
        lp = 16'hBEEF;
        lc = 16'h0421;
        do_reset();
        for (int i = 0; i < FBITS + 1500; i++) step(1'b1);
        do_reset();
        for (int i = 0; i < 2100; i++) step(1'b1);

        // Directed: idle cycles mid-frame hold the output (R9)
        for (int i = 0; i < 40; i++) step(i % 2 == 0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule